// File: doc/BRIEF.md
# Serial Bit Transmit Handshake Controller

This block sequences the sending of one serial word, bit by bit, to a line interface. A host write arms it. It then waits for the line to say it can take a bit. It presents a bit-valid strobe for as long as the line holds that ready indication. When ready is released, it either goes through a one-cycle clock state to move the shift register on to the next bit, or, once the count-15 flag shows the last bit has gone, parks in a wakeup state that asks the host for attention. The shift register and the bit counter are outside the block. The block only decides when they should act, through its state code and the bit-valid strobe.

The handshake with the line works as valid/ready, with back-pressure held by the line. A bit is offered only after ready has been seen. The offer is held without change while ready stays asserted, and the line ends each transfer by dropping ready. A host write that is still asserted holds the block back from offering a bit. A start command skips the transfer and goes straight to wakeup. A clear command returns the block to idle from any state. All commands are synchronous, and the state and the strobe change one clock after the inputs that cause them.

Top module: `sertx_handshake`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the next cycle shows state 0 (idle) and `bit_valid` low.
- R2: The `state` output only ever carries one of the five codes idle=0, wait-for-ready=1, send-bit=2, wakeup=3, clock=5. Any other code in the state register leads to idle.
- R3: In idle, an asserted start command moves the state to wakeup on the next cycle, even when a write is also asserted. Otherwise an asserted write moves it to wait-for-ready. With neither asserted, it stays in idle.
- R4: In wait-for-ready, the state moves to send-bit when ready is asserted and write is not asserted. In every other case it holds.
- R5: In send-bit, the state holds while ready is asserted. When ready is deasserted, it moves to wakeup if count-15 is high, and to clock if count-15 is low.
- R6: Clock always moves to wait-for-ready on the next cycle.
- R7: Wakeup holds, whatever the write, start, ready and count-15 inputs do, until a clear command arrives.
- R8: An asserted clear command sends the state to idle on the next cycle from every state, overriding all other inputs.
- R9: `bit_valid` is registered together with the state, and is high in exactly those cycles in which `state` shows send-bit (2).
- R10: Clear, write, start and ready are asserted when low. Count-15 is asserted when high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Clear command, active low |
| wr_n | input | 1 | Host write strobe, active low |
| start_n | input | 1 | Output-start command, active low |
| cnt15 | input | 1 | Last-bit flag from the external counter, active high |
| rdy_n | input | 1 | Line ready-for-next-bit, active low |
| bit_valid | output | 1 | Bit offered to the line, high only in send-bit |
| state | output | 3 | Current state code |

## Verification
A bench model of the transition rules is stepped alongside the design. Random input patterns are weighted so that clear and start are rare, while write and ready toggle often. This reaches every state and every exit from it, and any wrong priority or polarity shows up as a state mismatch. A directed receiver holds ready for a varying number of cycles per bit across a full 16-bit word. This separates a correct hold in send-bit from a premature exit, and it confirms that only the sixteenth release of ready leads to wakeup. Directed cases also check that start outranks write in idle, that a lingering write holds wait-for-ready, and that clear from each reachable state wins over conflicting inputs.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int STATE_W = 3;
  localparam int CTL_W   = 5;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_SEND = 3'd2,
    ST_WAKE = 3'd3,
    ST_CLK  = 3'd5
  } tx_state_e;

  // decoded controls, all active high after polarity fix-up
  typedef struct packed {
    logic clr;
    logic wr;
    logic start;
    logic last;
    logic rdy;
  } tx_ctl_t;
endpackage

// File: rtl/sertx_in_decode.sv
module sertx_in_decode
  import sertx_pkg::*;
#(
  // one bit per control in tx_ctl_t order (clr, wr, start, last, rdy); 1 = pin is active low
  parameter logic [CTL_W-1:0] LOW_MASK = 5'b11101
) (
  input  logic    clr_pin,
  input  logic    wr_pin,
  input  logic    start_pin,
  input  logic    last_pin,
  input  logic    rdy_pin,
  output tx_ctl_t ctl
);
  logic [CTL_W-1:0] raw;
  assign raw = {clr_pin, wr_pin, start_pin, last_pin, rdy_pin};
  assign ctl = tx_ctl_t'(raw ^ LOW_MASK);
endmodule

// File: rtl/sertx_next.sv
module sertx_next
  import sertx_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  tx_ctl_t            ctl,
  output logic [STATE_W-1:0] nxt
);
  logic [STATE_W-1:0] flow;

  always_comb begin
    flow = cur;
    case (cur)
      ST_IDLE: begin
        if (ctl.start)   flow = ST_WAKE;
        else if (ctl.wr) flow = ST_WAIT;
      end
      ST_WAIT: begin
        if (ctl.rdy && !ctl.wr) flow = ST_SEND;
      end
      ST_SEND: begin
        if (!ctl.rdy) flow = ctl.last ? ST_WAKE : ST_CLK;
      end
      ST_CLK:  flow = ST_WAIT;
      ST_WAKE: flow = ST_WAKE;
      default: flow = ST_IDLE;
    endcase
  end

  assign nxt = ctl.clr ? ST_IDLE : flow;
endmodule

// File: rtl/sertx_state_reg.sv
module sertx_state_reg
  import sertx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] nxt,
  output logic [STATE_W-1:0] cur,
  output logic               valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      cur     <= nxt;
      valid_q <= (nxt == ST_SEND);
    end
  end

  // R1: reset lands in idle with the strobe low
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (cur == ST_IDLE && !valid_q));
endmodule

// File: rtl/sertx_handshake.sv
module sertx_handshake
  import sertx_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         wr_n,
  input  logic         start_n,
  input  logic         cnt15,
  input  logic         rdy_n,
  output logic         bit_valid,
  output logic [2:0]   state
);
  tx_ctl_t            ctl;
  logic [STATE_W-1:0] cur;
  logic [STATE_W-1:0] nxt;

  sertx_in_decode u_dec (
    .clr_pin   (clr_n),
    .wr_pin    (wr_n),
    .start_pin (start_n),
    .last_pin  (cnt15),
    .rdy_pin   (rdy_n),
    .ctl       (ctl)
  );

  sertx_next u_next (
    .cur (cur),
    .ctl (ctl),
    .nxt (nxt)
  );

  sertx_state_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .nxt     (nxt),
    .cur     (cur),
    .valid_q (bit_valid)
  );

  assign state = cur;

  // R8: clear wins over everything
  a_r8_clear_to_idle: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> state == 3'd0);
  // R3: start outranks write in idle
  a_r3_start_jump: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0 && clr_n && !start_n) |=> state == 3'd3);
  // R4: a lingering write keeps the block waiting
  a_r4_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 && clr_n && !wr_n) |=> state == 3'd1);
  // R5: send holds while the line keeps ready asserted
  a_r5_send_hold: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd2 && clr_n && !rdy_n) |=> (state == 3'd2 && bit_valid));
  // R6: clock lasts one cycle
  a_r6_clock_once: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd5 && clr_n) |=> state == 3'd1);
  // R7: wakeup sticks until clear
  a_r7_wake_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd3 && clr_n) |=> state == 3'd3);
  // R9: strobe follows the send state
  a_r9_valid_send: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1 && clr_n && wr_n && !rdy_n) |=> bit_valid);
  // R2: only the five codes are visible
  a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
    state != 3'd4 && state != 3'd6 && state != 3'd7);
endmodule

// File: tb/sertx_handshake_tb_top.sv
module sertx_handshake_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1, wr_n = 1'b1, start_n = 1'b1, cnt15 = 1'b0, rdy_n = 1'b1;
  logic bit_valid;
  logic [2:0] state;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [2:0] exp_st = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_handshake dut_i (
    .clk(clk), .rst(rst), .clr_n(clr_n), .wr_n(wr_n), .start_n(start_n),
    .cnt15(cnt15), .rdy_n(rdy_n), .bit_valid(bit_valid), .state(state)
  );

  // reference transition rules, arguments active high
  function automatic logic [2:0] model(logic [2:0] s, bit clr, bit wr, bit st, bit last, bit rdy);
    logic [2:0] n;
    n = s;
    case (s)
      3'd0: if (st) n = 3'd3; else if (wr) n = 3'd1;
      3'd1: if (rdy && !wr) n = 3'd2;
      3'd2: if (!rdy) n = last ? 3'd3 : 3'd5;
      3'd5: n = 3'd1;
      3'd3: n = 3'd3;
      default: n = 3'd0;
    endcase
    if (clr) n = 3'd0;
    return n;
  endfunction

  function automatic string tag_for(logic [2:0] s, bit clr);
    if (clr) return "R8";
    case (s)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // one cycle: inputs set now (at negedge), result checked at next negedge
  task automatic cyc(bit clr, bit wr, bit st, bit last, bit rdy);
    string t;
    t = tag_for(exp_st, clr);
    clr_n = ~clr; wr_n = ~wr; start_n = ~st; cnt15 = last; rdy_n = ~rdy;
    exp_st = model(exp_st, clr, wr, st, last, rdy);
    @(posedge clk);
    @(negedge clk);
    cycles++;
    check(t, state, exp_st);
    check("R9", bit_valid, (exp_st == 3'd2));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired, R1 run did not complete");
    summary();
  end

  initial begin
    int sends;
    void'($urandom(32'd4711));
    // R1: reset
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", state, 0);
    check("R1", bit_valid, 0);
    rst = 1'b0;
    exp_st = 3'd0;

    // R10: inactive levels leave idle alone; low write arms
    cyc(0, 0, 0, 1, 0);
    check("R10", state, 0);
    cyc(0, 1, 0, 0, 0);
    check("R10", state, 1);
    // R4: write still low holds even with ready
    cyc(0, 1, 0, 0, 1);
    check("R4", state, 1);

    // full 16-bit transfer with a receiver holding ready for varying lengths
    sends = 0;
    for (int b = 0; b < 16; b++) begin
      int hold;
      hold = 1 + (b % 3);
      cyc(0, 0, 0, 0, 0);            // line not yet ready
      for (int h = 0; h < hold; h++) begin
        cyc(0, 0, 0, (b == 15), 1);  // ready held: send
        if (h == 0 && state == 3'd2) sends++;
      end
      cyc(0, 0, 0, (b == 15), 0);    // ready released
      if (b != 15) cyc(0, 0, 0, 0, 0); // clock back to wait
    end
    check("R5", sends, 16);
    check("R5", state, 3);
    // R7: wakeup ignores traffic
    cyc(0, 1, 1, 1, 1);
    cyc(0, 0, 0, 0, 0);
    check("R7", state, 3);
    // R8: clear from wakeup
    cyc(1, 1, 1, 1, 1);
    check("R8", state, 0);

    // R3: start outranks write
    cyc(0, 1, 1, 0, 0);
    check("R3", state, 3);
    cyc(1, 0, 0, 0, 0);
    // R8: clear overrides in send
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    check("R5", state, 2);
    cyc(1, 0, 0, 0, 1);
    check("R8", state, 0);
    // R6: clock then wait
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    check("R6", state, 5);
    cyc(0, 0, 0, 0, 0);
    check("R6", state, 1);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      bit c, w, s, l, r;
      c = ($urandom % 16) == 0;
      w = ($urandom % 3) == 0;
      s = ($urandom % 20) == 0;
      l = ($urandom % 4) == 0;
      r = ($urandom % 2) == 0;
      cyc(c, w, s, l, r);
      check("R2", (state inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5}) ? 1 : 0, 1);
    end

    summary();
  end
endmodule